// File: doc/BRIEF.md
# Strobed 64-word by 1-bit static RAM

This block is a clock-cycle model of a small static memory of 64 single-bit words. A six-bit address selects one word through full decoding. An access takes place only on a clock edge where the strobe and both chip-enable inputs are high together. A read/write select picks the kind of access: low writes the data input into the addressed word, high reads it.

The output stands in for a three-state pin. It is a data bit `dout` plus an enable flag `dout_oe`. While the memory is not being read, the output is disabled and `dout` is held at 0. A read goes through a fixed order of output states. The output is disabled before the read. It is then driven LOW for a parameterised number of clock cycles, the access latency. Only after that does it show the stored bit.

Consecutive reads may keep the select high, and consecutive writes may keep it low. The select does not need to toggle between accesses of the same kind. The synchronous reset stops any read in progress but keeps the stored words.

Top module: `strobe_sram64`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output after that edge has `dout_oe` = 0 and `dout` = 0.
- R2: On an edge where any of `strobe`, `ce_a`, `ce_b` is 0, no word changes and the output after that edge is disabled, whatever the levels of `rd_wr_n` and `din`.
- R3: On an edge where all three enables are 1 and `rd_wr_n` = 0, `din` is stored in the word at `addr`, and the output after that edge is disabled. This holds also when it ends a read.
- R4: A read is an edge with all three enables at 1 and `rd_wr_n` = 1. When it starts from a disabled output, `dout_oe` = 1 and `dout` = 0 for exactly ACC_CYCLES cycles. After that the data is shown.
- R5: Once the latency has elapsed, `dout` equals the bit last written to the addressed word, with no inversion.
- R6: If the address changes between two consecutive read edges, the LOW phase restarts for ACC_CYCLES cycles before the new word is shown.
- R7: Holding `rd_wr_n` high over consecutive reads of one address keeps valid data with no new LOW phase. Holding it low over consecutive writes stores every write.
- R8: Reset does not clear the stored words. A reset during a read disables the output, and the next read goes through the full LOW phase again.
- R9: All 64 addresses select distinct words, so a write to one address leaves every other word unchanged.
- R10: Whenever `dout_oe` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; leaves the storage intact |
| strobe | input | 1 | Access strobe, active high |
| ce_a | input | 1 | First chip enable, active high |
| ce_b | input | 1 | Second chip enable, active high |
| rd_wr_n | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W (6) | Word address |
| din | input | 1 | Data to be written |
| dout | output | 1 | Output data; 0 while disabled or during the LOW phase |
| dout_oe | output | 1 | Output enable; 0 stands for high impedance |

## Verification
The bench builds the block with ADDR_W = 6 and ACC_CYCLES = 3. At that latency the LOW phase lasts several cycles, so an address change can land both in the middle of the LOW phase and after the data has become valid. The full 64-word space is written and then read back completely. Each of the three enables is dropped in turn during write attempts, and a reset is applied part-way through a read.

// File: rtl/sram64_pkg.sv
// Shared types for the strobed single-bit RAM.
// Assumes: nothing beyond the SystemVerilog package scope.
package sram64_pkg;

    // Output phase of the read sequencer: disabled, driven low, valid data.
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_LOW   = 2'd1,
        PH_VALID = 2'd2
    } rd_phase_t;

endpackage

// File: rtl/sram64_decode.sv
// Access qualification and one-hot word-write decode.
// Forms the combined select from the strobe and both chip enables, splits
// it into read and write requests, and decodes the address into one write
// enable per word. Assumes: addr is stable around the clock edge.
module sram64_decode #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              strobe,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_go,
    output logic              wr_go,
    output logic [DEPTH-1:0]  word_we
);

    logic sel;

    // Purpose: an access needs all three enables high together.
    always_comb begin
        sel   = strobe & ce_a & ce_b;
        rd_go = sel & rd_wr_n;
        wr_go = sel & ~rd_wr_n;
    end

    // Purpose: one write enable per word, at most one active.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        assign word_we[gi] = wr_go && (addr == ADDR_W'(gi));
    end

endmodule

// File: rtl/sram64_array.sv
// Storage array of DEPTH single-bit words, with no reset.
// Each word captures din on the rising edge at which its own enable is
// set. Read is an asynchronous multiplexer on rd_addr.
// Assumes: word_we has at most one bit set.
module sram64_array #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [DEPTH-1:0]  word_we,
    input  logic              din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);

    logic [DEPTH-1:0] bits;

    // Purpose: one storage flop per word, written only when enabled.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (word_we[gi]) begin
                bits[gi] <= din;
            end
        end
    end

    // Purpose: select the addressed word for the output stage.
    always_comb begin
        rd_bit = bits[rd_addr];
    end

endmodule

// File: rtl/sram64_rdseq.sv
// Read sequencer. It moves the output through the disabled, LOW and
// valid phases. A read that starts from a disabled output, or one whose
// address differs from the latched address, opens a LOW phase lasting
// ACC_CYCLES cycles. Any edge that is not a read disables the output.
// Assumes: ACC_CYCLES >= 1.
module sram64_rdseq
    import sram64_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int ACC_CYCLES = 2,
    localparam int CNT_W     = $clog2(ACC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] addr,
    output rd_phase_t         phase,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_CYCLES);

    logic [CNT_W-1:0] low_cnt;
    logic             restart;

    // Purpose: detect a read that must begin a fresh LOW phase.
    always_comb begin
        restart = (phase == PH_OFF) || (addr != rd_addr);
    end

    // Purpose: advance the phase and the latency counter on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_OFF;
            low_cnt <= '0;
            rd_addr <= '0;
        end else if (rd_go) begin
            if (restart) begin
                phase   <= PH_LOW;
                low_cnt <= CNT_ONE;
                rd_addr <= addr;
            end else if (phase == PH_LOW) begin
                if (low_cnt == CNT_LAST) begin
                    phase <= PH_VALID;
                end else begin
                    low_cnt <= low_cnt + CNT_ONE;
                end
            end
        end else begin
            phase   <= PH_OFF;
            low_cnt <= '0;
        end
    end

endmodule

// File: rtl/strobe_sram64.sv
// Top of the strobed 64x1 static RAM model. It ties together the decode,
// the storage array and the read sequencer, and forms the output pair
// that stands in for a three-state pin.
// Assumes: inputs are synchronous to clk; the stored contents are
// undefined until written.
module strobe_sram64
    import sram64_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int ACC_CYCLES = 2,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe
);

    logic              rd_go;
    logic              wr_go;
    logic [DEPTH-1:0]  word_we;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_bit;
    rd_phase_t         phase;

    sram64_decode #(.ADDR_W(ADDR_W)) u_decode (
        .strobe  (strobe),
        .ce_a    (ce_a),
        .ce_b    (ce_b),
        .rd_wr_n (rd_wr_n),
        .addr    (addr),
        .rd_go   (rd_go),
        .wr_go   (wr_go),
        .word_we (word_we)
    );

    sram64_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .word_we (word_we),
        .din     (din),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

    sram64_rdseq #(.ADDR_W(ADDR_W), .ACC_CYCLES(ACC_CYCLES)) u_rdseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (rd_go),
        .addr    (addr),
        .phase   (phase),
        .rd_addr (rd_addr)
    );

    // Purpose: enable the output outside the disabled phase; show data
    // only in the valid phase.
    always_comb begin
        dout_oe = (phase != PH_OFF);
        dout    = (phase == PH_VALID) & rd_bit;
    end

endmodule

// File: rtl/sram64_chk.sv
// Protocol checker for strobe_sram64. It watches only the top-level
// ports and is attached to every instance by the bind below.
// Assumes: rst_n is synchronous and active low.
module sram64_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              ce_a,
    input logic              ce_b,
    input logic              rd_wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dout,
    input logic              dout_oe
);

    logic sel;
    assign sel = strobe & ce_a & ce_b;

    // R2: an edge without the full select leaves the output disabled.
    p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !dout_oe);

    // R3: a write edge leaves the output disabled.
    p_write_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rd_wr_n) |=> !dout_oe);

    // R4: a read edge enables the output.
    p_read_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_wr_n) |=> dout_oe);

    // R4: the first enabled cycle is always the LOW state.
    p_first_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout);

    // R6: a read at a new address re-enters the LOW state.
    p_addr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_wr_n && $past(sel && rd_wr_n) && addr != $past(addr))
        |=> (dout_oe && !dout));

    // R10: a disabled output carries 0.
    p_zero_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

endmodule

bind strobe_sram64 sram64_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .ce_a    (ce_a),
    .ce_b    (ce_b),
    .rd_wr_n (rd_wr_n),
    .addr    (addr),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/sim_strobe_sram64.sv
`timescale 1ns/1ps
// Bench for strobe_sram64. A behavioural reference model is updated on
// every clock and compared with the outputs 2 ns after each rising edge.
module sim_strobe_sram64;

    localparam int ADDR_W = 6;
    localparam int ACC    = 3;
    localparam int WORDS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic              ce_a = 1'b0;
    logic              ce_b = 1'b0;
    logic              rd_wr_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              din = 1'b0;
    logic              dout;
    logic              dout_oe;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    // Reference state: stored words, phase 0 off / 1 low / 2 valid.
    bit  ref_mem [WORDS];
    int  ref_ph   = 0;
    int  ref_cnt  = 0;
    int  ref_addr = 0;

    always #4 clk = ~clk;

    strobe_sram64 #(.ADDR_W(ADDR_W), .ACC_CYCLES(ACC)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .ce_a    (ce_a),
        .ce_b    (ce_b),
        .rd_wr_n (rd_wr_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    function automatic bit pattern(input int a);
        return bit'(((a * 37) >> 2) ^ a);
    endfunction

    task automatic step(input bit s, input bit ca, input bit cb, input bit rw,
                        input int a, input bit d, input bit rn, input string tag);
        bit exp_oe;
        bit exp_d;
        strobe = s; ce_a = ca; ce_b = cb; rd_wr_n = rw;
        addr = ADDR_W'(a); din = d; rst_n = rn;
        @(posedge clk);
        if (!rn) begin
            ref_ph = 0; ref_cnt = 0;
        end else if (s && ca && cb && !rw) begin
            ref_mem[a] = d; ref_ph = 0;
        end else if (s && ca && cb && rw) begin
            if (ref_ph == 0 || a != ref_addr) begin
                ref_ph = 1; ref_cnt = 1; ref_addr = a;
            end else if (ref_ph == 1) begin
                if (ref_cnt == ACC) ref_ph = 2;
                else ref_cnt++;
            end
        end else begin
            ref_ph = 0;
        end
        #2;
        exp_oe = (ref_ph != 0);
        exp_d  = (ref_ph == 2) ? ref_mem[ref_addr] : 1'b0;
        checks++;
        if (dout_oe !== exp_oe || dout !== exp_d) begin
            errors++;
            $display("FAIL %s: dout_oe=%0b dout=%0b, expected dout_oe=%0b dout=%0b",
                     tag, dout_oe, dout, exp_oe, exp_d);
        end
    endtask

    task automatic rd(input int a, input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 1, 1, 1, a, 0, 1, tag);
    endtask

    task automatic wr(input int a, input bit d, input string tag);
        step(1, 1, 1, 0, a, d, 1, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 1, 0, 0, 1, tag);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, 0, "R1");
        // R9, R7: fill every word with rd_wr_n held low
        for (int a = 0; a < WORDS; a++) wr(a, pattern(a), "R9");
        idle("R2");
        // R4, R5, R7: one long read of a single address
        rd(5, ACC + 4, "R4");
        rd(6, ACC + 2, "R5");
        // R6: address change during the LOW phase and after valid data
        rd(9, 2, "R6");
        rd(10, ACC + 2, "R6");
        rd(11, ACC + 1, "R6");
        // R3: a write ends a read and disables the output
        wr(12, 1, "R3");
        wr(12, 0, "R3");
        rd(12, ACC + 1, "R3");
        wr(13, 1, "R3");
        rd(13, ACC + 1, "R5");
        // R2: each enable low in turn blocks a write of inverted data
        step(0, 1, 1, 0, 20, ~pattern(20), 1, "R2");
        step(1, 0, 1, 0, 20, ~pattern(20), 1, "R2");
        step(1, 1, 0, 0, 20, ~pattern(20), 1, "R2");
        step(1, 0, 0, 1, 20, 0, 1, "R2");
        rd(20, ACC + 1, "R2");
        step(0, 1, 1, 1, 20, 0, 1, "R2");
        // R8: reset in the middle of a read, storage retained
        rd(30, 2, "R8");
        step(1, 1, 1, 1, 30, 0, 0, "R8");
        rd(30, ACC + 2, "R8");
        step(1, 1, 1, 1, 30, 0, 0, "R8");
        rd(31, ACC + 1, "R8");
        // R9: read the whole array back, consecutive reads
        for (int a = 0; a < WORDS; a++) rd(a, ACC + 1, "R9");
        // R10: idle cycles with toggling data and select
        for (int i = 0; i < 4; i++) step(0, 1, 0, i % 2, i, 1, 1, "R10");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule